// File: doc/BRIEF.md
# Dual-Mode Serial Shift/Count Port

This block is the 4-bit serial data register of a small 4-bit controller. A registered mode bit selects its personality. In shift mode it moves one place left on every instruction-cycle strobe, taking the serial input into bit 0. In count mode it becomes a down-counter that steps once for each qualified high-to-low transition on the serial input.

Two further outputs depend on the mode. The serial data output and the serial clock output are selected from a second registered enable bit, the register's top bit and a clock-gate latch. An exchange strobe swaps the register with the accumulator. In the same cycle it loads the clock-gate latch from the carry. Instruction decode and the rest of the CPU sit outside this block and drive the strobes.

Top module: `sio_port`

## Requirements
- R1: While rst_ni is low and after it rises, the register reads 0, the clock-gate latch is 0, and both enable bits are 0. As a result so_o = 0 and sk_o = 0.
- R2: On a clock edge with mode_we_i = 1, the count enable takes mode_cnt_i and the output enable takes so_en_i. The count enable is 1 for count mode and 0 for shift mode.
- R3: The serial input passes through a two-flop synchronizer, so the sampled value is si_i as it stood two clock edges earlier. In shift mode, a clock edge with cyc_i = 1 and xchg_i = 0 loads {sio[2:0], sample} into the register.
- R4: The synchronized sample enters a two-deep history on every cyc_i edge. A fall is a cyc_i edge whose new sample is 0, whose previous sample is 0 and whose sample before that is 1. In count mode, a fall with xchg_i = 0 decrements the register by one, and 0 wraps to 15.
- R5: A low level seen at only one strobe is not counted. A level that stays low is counted once.
- R6: In count mode, so_o equals the output enable and sk_o equals the clock-gate latch.
- R7: In shift mode, so_o = sio[3] when the output enable is 1 and 0 otherwise, and sk_o = latch AND cyc_i.
- R8: acc_o always shows the register. On a clock edge with xchg_i = 1, the register takes acc_i and the latch takes carry_i, and this overrides any shift or count in the same edge.
- R9: With cyc_i = 0 and xchg_i = 0, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cyc_i | input | 1 | instruction-cycle strobe |
| si_i | input | 1 | serial input |
| mode_we_i | input | 1 | enable-bit write strobe |
| mode_cnt_i | input | 1 | count enable value (1 = count) |
| so_en_i | input | 1 | output enable value |
| xchg_i | input | 1 | exchange strobe |
| acc_i | input | 4 | accumulator value to load |
| carry_i | input | 1 | carry loaded into the clock-gate latch |
| so_o | output | 1 | serial data output |
| sk_o | output | 1 | serial clock output |
| sio_o | output | 4 | register value |
| acc_o | output | 4 | register value returned to the accumulator |

## Verification
Some properties are checked on every cycle by assertions:
- the shift step, the decrement with its wrap, the priority of an exchange, and holding when idle;
- falls never occurring on two strobes in a row;
- the enable-bit loads and the count-mode output selection.

Other behaviour only the bench scenarios can show:
- whether a one-strobe low glitch is ignored while a held low counts exactly once;
- the two-edge synchronizer latency seen at the ports;
- the full output mux under random mixes of strobes, mode changes and exchanges.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_COUNT = 1'b1
  } sio_mode_e;
endpackage

// File: rtl/sio_sync_edge.sv
module sio_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic si_i,
  input  logic cyc_i,
  output logic si_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [1:0]        hist_q; // [0] newest strobe sample

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= si_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], si_i};
    end
  endgenerate

  assign si_s_o = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    hist_q <= '0;
    else if (cyc_i) hist_q <= {hist_q[0], si_s_o};

  // high, low, low across three strobe samples
  assign fall_o = cyc_i & ~si_s_o & ~hist_q[0] & hist_q[1];

  a_r5_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sio_core.sv
module sio_core
  import sio_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_i,
  input  sio_mode_e    mode_i,
  input  logic         si_s_i,
  input  logic         fall_i,
  input  logic         xchg_i,
  input  logic [W-1:0] acc_i,
  input  logic         carry_i,
  output logic [W-1:0] sio_o,
  output logic         skl_o
);
  logic [W-1:0] sio_q, sio_d;
  logic         skl_q;

  always_comb begin
    sio_d = sio_q;
    if (xchg_i)                              sio_d = acc_i;
    else if (mode_i == MODE_COUNT && fall_i) sio_d = sio_q - W'(1);
    else if (mode_i == MODE_SHIFT && cyc_i)  sio_d = {sio_q[W-2:0], si_s_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sio_q <= '0;
      skl_q <= 1'b0;
    end else begin
      sio_q <= sio_d;
      if (xchg_i) skl_q <= carry_i;
    end

  assign sio_o = sio_q;
  assign skl_o = skl_q;

  a_r3_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i && !xchg_i && mode_i == MODE_SHIFT) |=>
      sio_q == {$past(sio_q[W-2:0]), $past(si_s_i)});
  a_r4_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !xchg_i && mode_i == MODE_COUNT) |=> sio_q == $past(sio_q) - W'(1));
  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !xchg_i && mode_i == MODE_COUNT && sio_q == '0) |=> sio_q == '1);
  a_r8_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i |=> (sio_q == $past(acc_i)) && (skl_q == $past(carry_i)));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_i && !xchg_i) |=> $stable(sio_q));
endmodule

// File: rtl/sio_out_mux.sv
module sio_out_mux
  import sio_pkg::*;
(
  input  sio_mode_e mode_i,
  input  logic      so_en_i,
  input  logic      msb_i,
  input  logic      skl_i,
  input  logic      cyc_i,
  output logic      so_o,
  output logic      sk_o
);
  always_comb begin
    if (mode_i == MODE_COUNT) begin
      so_o = so_en_i;
      sk_o = skl_i;
    end else begin
      so_o = so_en_i & msb_i;
      sk_o = skl_i & cyc_i;
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cyc_i,
  input  logic         si_i,
  input  logic         mode_we_i,
  input  logic         mode_cnt_i,
  input  logic         so_en_i,
  input  logic         xchg_i,
  input  logic [W-1:0] acc_i,
  input  logic         carry_i,
  output logic         so_o,
  output logic         sk_o,
  output logic [W-1:0] sio_o,
  output logic [W-1:0] acc_o
);
  sio_mode_e    mode_q;
  logic         so_en_q;
  logic         si_s, fall, skl;
  logic [W-1:0] sio;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q  <= MODE_SHIFT;
      so_en_q <= 1'b0;
    end else if (mode_we_i) begin
      mode_q  <= sio_mode_e'(mode_cnt_i);
      so_en_q <= so_en_i;
    end

  sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .si_i, .cyc_i, .si_s_o(si_s), .fall_o(fall)
  );

  sio_core #(.W(W)) u_core (
    .clk_i, .rst_ni, .cyc_i, .mode_i(mode_q), .si_s_i(si_s), .fall_i(fall),
    .xchg_i, .acc_i, .carry_i, .sio_o(sio), .skl_o(skl)
  );

  sio_out_mux u_mux (
    .mode_i(mode_q), .so_en_i(so_en_q), .msb_i(sio[W-1]), .skl_i(skl),
    .cyc_i, .so_o, .sk_o
  );

  assign sio_o = sio;
  assign acc_o = sio;

  a_r2_mode_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_q == sio_mode_e'($past(mode_cnt_i))) && (so_en_q == $past(so_en_i)));
  a_r6_count_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_COUNT) |-> (so_o == so_en_q) && (sk_o == skl));
  a_r7_so_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SHIFT && !so_en_q) |-> !so_o);
  a_r7_sk_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SHIFT && !skl) |-> !sk_o);
endmodule

// File: tb/sio_port_tb_top.sv
`timescale 1ns/1ps
module sio_port_tb_top;
  logic clk = 0, rst_ni = 0;
  logic cyc = 0, si = 0, mwe = 0, mcnt = 0, soen = 0, xchg = 0, carry = 0;
  logic [3:0] acc = 0;
  logic so, sk;
  logic [3:0] sio, acc_o;
  int n_chk = 0, n_fail = 0;

  // bench model state
  logic s1, s2, h0, h1, m_skl, m_en0, m_en3;
  logic [3:0] m_sio;

  always #2 clk = ~clk;

  sio_port dut_i (
    .clk_i(clk), .rst_ni, .cyc_i(cyc), .si_i(si), .mode_we_i(mwe), .mode_cnt_i(mcnt),
    .so_en_i(soen), .xchg_i(xchg), .acc_i(acc), .carry_i(carry),
    .so_o(so), .sk_o(sk), .sio_o(sio), .acc_o(acc_o)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_so();
    return m_en0 ? m_en3 : (m_en3 & m_sio[3]);
  endfunction
  function automatic logic exp_sk(logic c);
    return m_en0 ? m_skl : (m_skl & c);
  endfunction

  task automatic model_reset();
    {s1, s2, h0, h1, m_skl, m_en0, m_en3} = '0;
    m_sio = 0;
  endtask

  // inputs already set after a negedge; check, then advance through one posedge
  task automatic step();
    logic fall;
    #0.5;
    chk("R3/R4 sio", sio, m_sio);
    chk("R8 acc_o", acc_o, m_sio);
    chk("R6/R7 so", {3'b0, so}, {3'b0, exp_so()});
    chk("R6/R7 sk", {3'b0, sk}, {3'b0, exp_sk(cyc)});
    @(posedge clk);
    fall = cyc & ~s2 & ~h0 & h1;
    if (xchg) begin m_sio = acc; m_skl = carry; end
    else if (m_en0 && fall) m_sio = m_sio - 4'd1;
    else if (!m_en0 && cyc) m_sio = {m_sio[2:0], s2};
    if (cyc) begin h1 = h0; h0 = s2; end
    s2 = s1; s1 = si;
    if (mwe) begin m_en0 = mcnt; m_en3 = soen; end
    @(negedge clk);
    {cyc, mwe, xchg} = '0;
  endtask

  task automatic set_mode(logic c, logic e);
    mwe = 1; mcnt = c; soen = e; step();
  endtask
  task automatic load(logic [3:0] v, logic cr);
    xchg = 1; acc = v; carry = cr; step();
  endtask
  task automatic strobes(logic s, int n);
    for (int i = 0; i < n; i++) begin si = s; cyc = 1; step(); end
  endtask

  initial begin
    fork
      begin
        model_reset();
        repeat (3) @(negedge clk);
        #0.5;
        chk("R1 sio", sio, 0);
        chk("R1 so/sk", {2'b0, so, sk}, 0);
        rst_ni = 1;
        @(negedge clk);
        step();
        // R2 and R6: count mode with so enabled
        set_mode(1, 1);
        #0.5; chk("R6 so=en3", {3'b0, so}, 4'd1);
        // R4 wrap from 0 to 15
        load(4'd0, 1);
        strobes(1, 4); strobes(0, 4);
        chk("R4 wrap", sio, 4'd15);
        // R5 held low counts once more only after new high
        strobes(0, 4);
        chk("R5 held", sio, 4'd15);
        // R5 single-strobe low glitch ignored: high, one low sample, high
        strobes(1, 4);
        si = 0; cyc = 1; step();
        si = 1; cyc = 0; step();   // low seen by synchronizer for one edge only
        strobes(1, 4);
        chk("R5 glitch", sio, 4'd15);
        // R8 priority of exchange over a count edge
        strobes(0, 1);
        si = 0; cyc = 1; xchg = 1; acc = 4'd9; carry = 0; step();
        chk("R8 priority", sio, 4'd9);
        // R3/R7 shift mode
        set_mode(0, 1);
        load(4'd0, 1);
        strobes(1, 6);
        chk("R3 shift ones", sio, 4'hF);
        // R9 hold
        for (int i = 0; i < 5; i++) begin si = ~si; step(); end
        chk("R9 hold", sio, 4'hF);
        // random phase, fixed seed
        void'($urandom(32'h5a17));
        for (int i = 0; i < 4000; i++) begin
          if ($urandom % 4 == 0) si = ~si;
          cyc   = ($urandom % 3) != 0;
          xchg  = ($urandom % 12) == 0;
          acc   = 4'($urandom);
          carry = 1'($urandom);
          mwe   = ($urandom % 40) == 0;
          mcnt  = 1'($urandom);
          soen  = 1'($urandom);
          step();
        end
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=1 exp=0");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule